// File: doc/BRIEF.md
# QRS Enhancement Filter Pipeline

This block conditions a stream of signed ECG samples so that a later beat detector sees one compact energy bump per heartbeat. Each accepted sample passes through five fixed stages: a recursive integer low-pass filter, a high-pass filter built as a delayed sample minus a running mean, a five-point slope estimate, a squarer, and a 32-sample moving-window integrator. Every input sample yields exactly one non-negative energy value, in order.

All arithmetic is integer. Every division is a power of two and is done with an arithmetic shift, which rounds toward minus infinity. Internal widths grow from stage to stage so that no stage can wrap at full-scale input. The parameter `REG_MASK` decides, stage by stage, whether a register sits at that stage's output. The designer can therefore place pipeline slack where timing needs it, at a cost of one cycle of latency per set bit. When a boundary is left combinational, the stage feeds the next one in the same cycle.

Top module: `qrs_enhance`

## Requirements
- R1: A synchronous reset clears every delay line, running sum, recursion state and registered boundary. `out_valid` is low in the first cycle after reset is released. A registered output boundary also shows `out_energy` = 0 then.
- R2: The low-pass stage computes lp[n] = 2·lp[n-1] − lp[n-2] + x[n] − 2·x[n-6] + x[n-12], with no scaling. Its DC gain is 36.
- R3: The high-pass stage computes hp[n] = lp[n-16] − floor(S[n]/32). S[n] is the sum of lp[n] down to lp[n-31], kept as a running sum.
- R4: The slope stage computes d[n] = floor((2·hp[n] + hp[n-1] − hp[n-3] − 2·hp[n-4]) / 8), and its square is taken as an unsigned value.
- R5: The stage widths are low-pass IN_W+6, high-pass IN_W+7 and squarer 2·(IN_W+7). No stage wraps for any input sequence, including full-scale steps and ±full-scale alternation. `out_energy` never exceeds 2^(OUT_W−2).
- R6: The output is floor(W[n]/32). W[n] is the running sum of the 32 most recent squared slope values.
- R7: Each accepted sample produces exactly one output, in input order. Latency in cycles equals the number of set bits in `REG_MASK`. The mask bits are: bit 0 low-pass, bit 1 high-pass, bit 2 slope, bit 3 squarer, bit 4 integrator.
- R8: A cycle with `in_valid` low changes no stage state and produces no output, whatever value `in_sample` holds.
- R9: After reset, as long as every accepted sample is zero, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies `in_sample` for this cycle |
| in_sample | input | IN_W | Signed two's-complement ECG sample |
| out_valid | output | 1 | Qualifies `out_energy` |
| out_energy | output | OUT_W | Unsigned integrated slope energy, OUT_W = 2·(IN_W+7) |

## Verification
The checker relies on three assumptions about the inputs:
- Reset is applied before the first sample, which is what seeds its zero-input tracking and its model of valid timing.
- `in_sample` is read only in cycles where `in_valid` is high.
- The energy bound holds because a sample can never lie outside the signed IN_W range.

The bench meets these assumptions by holding reset from time zero and again in the middle of the run. It drives deliberately nonzero garbage on `in_sample` during invalid cycles, and it uses only values between −1024 and +1023, including both extremes held for long runs.

// File: rtl/qrs_pkg.sv
package qrs_pkg;

   // Index of each stage's boundary bit inside the register mask.
   typedef enum int {
      STG_LP  = 0,
      STG_HP  = 1,
      STG_DIF = 2,
      STG_SQR = 3,
      STG_WIN = 4
   } stage_e;

   function automatic int ones5(input logic [4:0] m);
      int n;
      n = 0;
      for (int i = 0; i < 5; i++) n += int'(m[i]);
      return n;
   endfunction

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/qrs_edge.sv
// Stage boundary: a register when EN is set, a wire otherwise.
module qrs_edge #(
   parameter int W  = 8,
   parameter bit EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         in_valid,
   input  logic [W-1:0] in_data,
   output logic         out_valid,
   output logic [W-1:0] out_data
);

   generate
      if (EN) begin : g_reg
         always_ff @(posedge clk) begin
            if (rst) begin
               out_valid <= 1'b0;
               out_data  <= '0;
            end else begin
               out_valid <= in_valid;
               if (in_valid) out_data <= in_data;
            end
         end
      end else begin : g_wire
         assign out_valid = in_valid;
         assign out_data  = in_data;
      end
   endgenerate

endmodule

// File: rtl/qrs_bandpass.sv
// Recursive integer low-pass followed by delay-minus-mean high-pass.
module qrs_bandpass #(
   parameter int IN_W   = 11,
   parameter int NOTCH  = 6,
   parameter int HP_LEN = 32,
   parameter int LP_W   = 17,
   parameter int HP_W   = 18,
   parameter bit REG_LP = 1'b1,
   parameter bit REG_HP = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   in_valid,
   input  logic signed [IN_W-1:0] in_data,
   output logic                   out_valid,
   output logic signed [HP_W-1:0] out_data
);

   localparam int LP_HIST = 2 * NOTCH;
   localparam int LP_ACC  = LP_W + 4;
   localparam int HP_SH   = $clog2(HP_LEN);
   localparam int HP_DLY  = HP_LEN / 2;
   localparam int SUM_W   = LP_W + HP_SH + 1;
   localparam int HP_ACC  = SUM_W + 1;

   // ---------------- low-pass recursion ----------------
   logic signed [IN_W-1:0]   lp_x [LP_HIST];
   logic signed [LP_W-1:0]   lp_y1, lp_y2, lp_now;
   logic signed [LP_ACC-1:0] lp_acc;

   always_comb begin
      lp_acc = (LP_ACC'(lp_y1) <<< 1) - LP_ACC'(lp_y2) + LP_ACC'(in_data)
             - (LP_ACC'(lp_x[NOTCH-1]) <<< 1) + LP_ACC'(lp_x[LP_HIST-1]);
      lp_now = LP_W'(lp_acc);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < LP_HIST; i++) lp_x[i] <= '0;
         lp_y1 <= '0;
         lp_y2 <= '0;
      end else if (in_valid) begin
         lp_x[0] <= in_data;
         for (int i = 1; i < LP_HIST; i++) lp_x[i] <= lp_x[i-1];
         lp_y2 <= lp_y1;
         lp_y1 <= lp_now;
      end
   end

   logic                   lp_v;
   logic [LP_W-1:0]        lp_q_raw;
   logic signed [LP_W-1:0] lp_q;

   qrs_edge #(.W(LP_W), .EN(REG_LP)) lp_edge_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(lp_now),
      .out_valid(lp_v), .out_data(lp_q_raw)
   );
   assign lp_q = signed'(lp_q_raw);

   // ---------------- high-pass: delayed sample minus mean ----------------
   logic signed [LP_W-1:0]   hp_x [HP_LEN];
   logic signed [SUM_W-1:0]  hp_sum, hp_sum_now;
   logic signed [HP_ACC-1:0] hp_acc;
   logic signed [HP_W-1:0]   hp_now;

   always_comb begin
      hp_sum_now = hp_sum + SUM_W'(lp_q) - SUM_W'(hp_x[HP_LEN-1]);
      hp_acc     = HP_ACC'(hp_x[HP_DLY-1]) - HP_ACC'(hp_sum_now >>> HP_SH);
      hp_now     = HP_W'(hp_acc);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < HP_LEN; i++) hp_x[i] <= '0;
         hp_sum <= '0;
      end else if (lp_v) begin
         hp_x[0] <= lp_q;
         for (int i = 1; i < HP_LEN; i++) hp_x[i] <= hp_x[i-1];
         hp_sum <= hp_sum_now;
      end
   end

   logic [HP_W-1:0] hp_q_raw;

   qrs_edge #(.W(HP_W), .EN(REG_HP)) hp_edge_i (
      .clk(clk), .rst(rst), .in_valid(lp_v), .in_data(hp_now),
      .out_valid(out_valid), .out_data(hp_q_raw)
   );
   assign out_data = signed'(hp_q_raw);

endmodule

// File: rtl/qrs_slope_energy.sv
// Five-point slope estimate followed by squaring.
module qrs_slope_energy #(
   parameter int IN_W  = 18,
   parameter int SQ_W  = 36,
   parameter bit REG_D = 1'b1,
   parameter bit REG_S = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   in_valid,
   input  logic signed [IN_W-1:0] in_data,
   output logic                   out_valid,
   output logic [SQ_W-1:0]        out_data
);

   localparam int D_ACC = IN_W + 3;

   generate
      if (SQ_W != 2 * IN_W) begin : g_bad_sq
         $error("qrs_slope_energy: SQ_W must be twice IN_W");
      end
   endgenerate

   logic signed [IN_W-1:0]  dx [4];
   logic signed [D_ACC-1:0] d_acc;
   logic signed [IN_W-1:0]  d_now;

   always_comb begin
      d_acc = (D_ACC'(in_data) <<< 1) + D_ACC'(dx[0])
            - D_ACC'(dx[2]) - (D_ACC'(dx[3]) <<< 1);
      d_now = IN_W'(d_acc >>> 3);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < 4; i++) dx[i] <= '0;
      end else if (in_valid) begin
         dx[0] <= in_data;
         for (int i = 1; i < 4; i++) dx[i] <= dx[i-1];
      end
   end

   logic                   d_v;
   logic [IN_W-1:0]        d_q_raw;
   logic signed [IN_W-1:0] d_q;
   logic signed [SQ_W-1:0] prod;
   logic [SQ_W-1:0]        sq_now;

   qrs_edge #(.W(IN_W), .EN(REG_D)) d_edge_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(d_now),
      .out_valid(d_v), .out_data(d_q_raw)
   );
   assign d_q    = signed'(d_q_raw);
   assign prod   = SQ_W'(d_q) * SQ_W'(d_q);
   assign sq_now = unsigned'(prod);

   qrs_edge #(.W(SQ_W), .EN(REG_S)) s_edge_i (
      .clk(clk), .rst(rst), .in_valid(d_v), .in_data(sq_now),
      .out_valid(out_valid), .out_data(out_data)
   );

endmodule

// File: rtl/qrs_window_sum.sv
// Moving-window integrator: running sum over LEN samples, divided by LEN.
module qrs_window_sum #(
   parameter int W       = 36,
   parameter int LEN     = 32,
   parameter bit REG_OUT = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         in_valid,
   input  logic [W-1:0] in_data,
   output logic         out_valid,
   output logic [W-1:0] out_data
);

   localparam int SH    = $clog2(LEN);
   localparam int SUM_W = W + SH;

   logic [W-1:0]     wx [LEN];
   logic [SUM_W-1:0] w_sum, w_sum_now;
   logic [W-1:0]     w_now;

   always_comb begin
      w_sum_now = w_sum + SUM_W'(in_data) - SUM_W'(wx[LEN-1]);
      w_now     = W'(w_sum_now >> SH);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < LEN; i++) wx[i] <= '0;
         w_sum <= '0;
      end else if (in_valid) begin
         wx[0] <= in_data;
         for (int i = 1; i < LEN; i++) wx[i] <= wx[i-1];
         w_sum <= w_sum_now;
      end
   end

   qrs_edge #(.W(W), .EN(REG_OUT)) w_edge_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(w_now),
      .out_valid(out_valid), .out_data(out_data)
   );

endmodule

// File: rtl/qrs_enhance.sv
module qrs_enhance
   import qrs_pkg::*;
#(
   parameter int         IN_W     = 11,
   parameter int         NOTCH    = 6,
   parameter int         HP_LEN   = 32,
   parameter int         WIN_LEN  = 32,
   parameter logic [4:0] REG_MASK = 5'b11111,
   localparam int        OUT_W    = 2 * (IN_W + $clog2(NOTCH * NOTCH) + 1)
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   in_valid,
   input  logic signed [IN_W-1:0] in_sample,
   output logic                   out_valid,
   output logic [OUT_W-1:0]       out_energy
);

   localparam int LP_W = IN_W + $clog2(NOTCH * NOTCH);
   localparam int HP_W = LP_W + 1;
   localparam int SQ_W = 2 * HP_W;

   generate
      if (IN_W < 4 || IN_W > 24) begin : g_bad_width
         $error("qrs_enhance: IN_W out of range");
      end
      if (NOTCH < 2) begin : g_bad_notch
         $error("qrs_enhance: NOTCH must be at least 2");
      end
      if (!is_pow2(HP_LEN) || !is_pow2(WIN_LEN)) begin : g_bad_len
         $error("qrs_enhance: window lengths must be powers of two");
      end
   endgenerate

   logic                   bp_v;
   logic signed [HP_W-1:0] bp_d;
   logic                   se_v;
   logic [SQ_W-1:0]        se_d;

   qrs_bandpass #(
      .IN_W(IN_W), .NOTCH(NOTCH), .HP_LEN(HP_LEN), .LP_W(LP_W), .HP_W(HP_W),
      .REG_LP(REG_MASK[int'(STG_LP)]), .REG_HP(REG_MASK[int'(STG_HP)])
   ) bp_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_sample),
      .out_valid(bp_v), .out_data(bp_d)
   );

   qrs_slope_energy #(
      .IN_W(HP_W), .SQ_W(SQ_W),
      .REG_D(REG_MASK[int'(STG_DIF)]), .REG_S(REG_MASK[int'(STG_SQR)])
   ) se_i (
      .clk(clk), .rst(rst), .in_valid(bp_v), .in_data(bp_d),
      .out_valid(se_v), .out_data(se_d)
   );

   qrs_window_sum #(
      .W(SQ_W), .LEN(WIN_LEN), .REG_OUT(REG_MASK[int'(STG_WIN)])
   ) win_i (
      .clk(clk), .rst(rst), .in_valid(se_v), .in_data(se_d),
      .out_valid(out_valid), .out_data(out_energy)
   );

endmodule

// File: rtl/qrs_enhance_chk.sv
module qrs_enhance_chk
   import qrs_pkg::*;
#(
   parameter int         IN_W     = 11,
   parameter int         OUT_W    = 36,
   parameter logic [4:0] REG_MASK = 5'b11111
) (
   input logic                   clk,
   input logic                   rst,
   input logic                   in_valid,
   input logic signed [IN_W-1:0] in_sample,
   input logic                   out_valid,
   input logic [OUT_W-1:0]       out_energy
);

   localparam int             LAT   = ones5(REG_MASK);
   localparam logic [OUT_W-1:0] E_MAX = OUT_W'(1) << (OUT_W - 2);

   // Independent model of when outputs may appear.
   logic [LAT:0]   v_sh;
   logic [LAT+1:0] v_next;
   assign v_next = {v_sh, in_valid};

   always_ff @(posedge clk) begin
      if (rst) v_sh <= '0;
      else     v_sh <= v_next[LAT:0];
   end

   // Tracks whether only zero samples have been accepted since reset.
   logic zero_run, zero_now;
   always_ff @(posedge clk) begin
      if (rst)                            zero_run <= 1'b1;
      else if (in_valid && in_sample != '0) zero_run <= 1'b0;
   end
   assign zero_now = zero_run && !(in_valid && in_sample != '0);

   p_reset_quiet_r1: assert property (@(posedge clk)
      rst |=> ((LAT == 0) || !out_valid));

   p_latency_r7: assert property (@(posedge clk) disable iff (rst)
      out_valid == v_next[LAT]);

   p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_energy <= E_MAX));

   p_zero_in_r9: assert property (@(posedge clk) disable iff (rst)
      (out_valid && zero_now) |-> (out_energy == '0));

endmodule

bind qrs_enhance qrs_enhance_chk #(
   .IN_W(IN_W), .OUT_W(OUT_W), .REG_MASK(REG_MASK)
) chk_i (
   .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
   .out_valid(out_valid), .out_energy(out_energy)
);

// File: tb/qrs_enhance_tb_top.sv
`timescale 1ns/1ps
module qrs_enhance_tb_top;

   localparam int IN_W  = 11;
   localparam int OUT_W = 36;
   localparam int LAT_A = 5;   // mask 11111
   localparam int LAT_B = 2;   // mask 00101: low-pass and slope registered

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic                   rst = 1'b1;
   logic                   in_valid = 1'b0;
   logic signed [IN_W-1:0] in_sample = '0;
   logic                   va, vb;
   logic [OUT_W-1:0]       ea, eb;

   qrs_enhance #(.IN_W(IN_W), .REG_MASK(5'b11111)) dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
      .out_valid(va), .out_energy(ea)
   );

   qrs_enhance #(.IN_W(IN_W), .REG_MASK(5'b00101)) dut_c (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
      .out_valid(vb), .out_energy(eb)
   );

   int     n_checks = 0;
   int     n_fail   = 0;
   longint cyc      = 0;
   string  tag      = "R1";
   always @(posedge clk) cyc <= cyc + 1;

   longint qa[$], qb[$], ca[$], cb[$];

   // ---------------- integer reference model ----------------
   longint m_lx[12], m_hx[32], m_dx[4], m_wx[32];
   longint m_ly1, m_ly2, m_hsum, m_wsum;

   task automatic model_reset();
      for (int i = 0; i < 12; i++) m_lx[i] = 0;
      for (int i = 0; i < 32; i++) begin m_hx[i] = 0; m_wx[i] = 0; end
      for (int i = 0; i < 4; i++) m_dx[i] = 0;
      m_ly1 = 0; m_ly2 = 0; m_hsum = 0; m_wsum = 0;
   endtask

   task automatic model_step(input longint x, output longint e);
      longint y, s, hp, a, d, sq, ws;
      y = 2 * m_ly1 - m_ly2 + x - 2 * m_lx[5] + m_lx[11];          // R2
      for (int i = 11; i > 0; i--) m_lx[i] = m_lx[i-1];
      m_lx[0] = x; m_ly2 = m_ly1; m_ly1 = y;
      s  = m_hsum + y - m_hx[31];                                   // R3
      hp = m_hx[15] - (s >>> 5);
      for (int i = 31; i > 0; i--) m_hx[i] = m_hx[i-1];
      m_hx[0] = y; m_hsum = s;
      a  = 2 * hp + m_dx[0] - m_dx[2] - 2 * m_dx[3];                // R4
      d  = a >>> 3;
      for (int i = 3; i > 0; i--) m_dx[i] = m_dx[i-1];
      m_dx[0] = hp;
      sq = d * d;
      ws = m_wsum + sq - m_wx[31];                                  // R6
      e  = ws >>> 5;
      for (int i = 31; i > 0; i--) m_wx[i] = m_wx[i-1];
      m_wx[0] = sq; m_wsum = ws;
   endtask

   task automatic check(input string req, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // ---------------- stimulus helpers ----------------
   task automatic send(input int x, input bit v);
      longint e;
      @(posedge clk); #1;
      in_valid  = v;
      in_sample = x[IN_W-1:0];
      if (v) begin
         model_step(longint'(in_sample), e);
         qa.push_back(e); qb.push_back(e);
         ca.push_back(cyc); cb.push_back(cyc);
      end
   endtask

   task automatic do_reset(input int n);
      @(posedge clk); #1;
      rst = 1'b1; in_valid = 1'b0; in_sample = 11'sd77;
      qa.delete(); qb.delete(); ca.delete(); cb.delete();
      model_reset();
      repeat (n) @(posedge clk);
      #1 rst = 1'b0;
      @(negedge clk);
      check("R1 out_valid A after reset", longint'(va), 0);
      check("R1 out_valid B after reset", longint'(vb), 0);
      check("R1 out_energy A after reset", longint'(ea), 0);
   endtask

   // ---------------- output monitors ----------------
   always @(negedge clk) begin
      longint e, c;
      if (rst === 1'b0 && va === 1'b1) begin
         if (qa.size() == 0) check("R8 spurious output A", 1, 0);
         else begin
            e = qa.pop_front(); c = ca.pop_front();
            check({tag, " R2 R3 R4 R6 value A"}, longint'(ea), e);
            check("R7 latency A", cyc - c, LAT_A);
            if (tag == "R9") check("R9 zero output A", longint'(ea), 0);
         end
      end
   end

   always @(negedge clk) begin
      longint e, c;
      if (rst === 1'b0 && vb === 1'b1) begin
         if (qb.size() == 0) check("R8 spurious output B", 1, 0);
         else begin
            e = qb.pop_front(); c = cb.pop_front();
            check({tag, " R2 R3 R4 R6 value B"}, longint'(eb), e);
            check("R7 latency B", cyc - c, LAT_B);
         end
      end
   end

   // ---------------- watchdog ----------------
   initial begin
      repeat (60000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   // ---------------- main sequence ----------------
   initial begin
      logic [15:0] lf;
      lf = 16'hACE1;
      model_reset();
      do_reset(3);

      tag = "R9";
      for (int i = 0; i < 48; i++) send(0, 1'b1);

      tag = "R2";                       // impulse response
      send(1023, 1'b1);
      for (int i = 0; i < 80; i++) send(0, 1'b1);

      tag = "R5";                       // full-scale steps and alternation
      for (int i = 0; i < 100; i++) send(1023, 1'b1);
      for (int i = 0; i < 100; i++) send(-1024, 1'b1);
      for (int i = 0; i < 80; i++) send((i % 2 == 0) ? 1023 : -1024, 1'b1);
      for (int i = 0; i < 60; i++) send(((i / 6) % 2 == 0) ? 1023 : -1024, 1'b1);

      tag = "R8";                       // random samples with idle gaps
      for (int i = 0; i < 600; i++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         send(int'($signed(lf[15:5])), lf[0] | lf[1]);
      end

      tag = "R6";                       // beat-like pulse train
      for (int i = 0; i < 240; i++) begin
         int k;
         k = i % 40;
         send((k < 4) ? k * 250 : ((k < 8) ? (8 - k) * 250 - 100 : -60), 1'b1);
      end

      tag = "R1";                       // reset in the middle of a stream
      do_reset(2);
      send(-1024, 1'b1);
      for (int i = 0; i < 60; i++) send(0, 1'b1);

      for (int i = 0; i < 10; i++) send(5, 1'b0);
      @(negedge clk);
      check("R7 no outputs lost A", longint'(qa.size()), 0);
      check("R7 no outputs lost B", longint'(qb.size()), 0);

      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule